// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a processor core in a small last-in, first-out store. A call pushes the address to come back to, and a return pops it, after which the next entry down appears on `tos_o`. The entry count is a parameter, a power of two of at most 32. The pointer names the top entry by its index. When the store holds nothing it carries a distinct code, 0x20, which lies outside every valid index.

Software reaches the block through a small register window. One byte holds the pointer code together with two sticky error flags. Two more bytes give the low and high parts of the top entry, and software may both read and write them. An overflow or an underflow always raises its flag. A static enable input decides whether the same event also pulses a reset-request output toward the reset controller.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous active-low reset the pointer byte reads 0x20, both flags are clear, `tos_o` is 0 and `reset_req_o` is low.
- R2: A push with the stack empty moves the pointer to index 0. Any other push that is not at the top index moves the pointer up by one. In both cases `push_addr_i` is stored there and appears on `tos_o` from the next cycle.
- R3: A pop with the pointer at an index above 0 moves the pointer down by one, and the entry below appears on `tos_o`. A pop at index 0 sets the pointer code to 0x20.
- R4: A push with the pointer at index DEPTH-1 sets the overflow flag (pointer byte bit 7). No entry changes and the pointer stays put.
- R5: A pop while empty sets the underflow flag (pointer byte bit 6) and leaves the pointer at 0x20. While the stack is empty, `tos_o` and both entry bytes read 0.
- R6: Both flags stay set until software writes the pointer byte with that bit at 0. Writing a 1 never sets a flag.
- R7: Writing the pointer byte (select 0) with bit 5 set empties the stack. Otherwise the pointer takes the written bits 4:0 masked with DEPTH-1. The byte reads as {overflow, underflow, bit5 = empty, bits 4:0 = index or 0}.
- R8: Select 1 reads or writes bits 7:0 of the top entry. Select 2 reads or writes bits ADDR_W-1:8, and its unused upper bits read as 0. Select 3 reads 0. An entry-byte write while empty is ignored.
- R9: With `err_rst_en_i` high, the cycle after an overflow or underflow event shows `reset_req_o` high for exactly one cycle. With it low, `reset_req_o` stays low.
- R10: When push and pop are both asserted, only the pop takes place. A register write in a cycle that has a push or a pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_addr_i | input | ADDR_W | Address to push |
| tos_o | output | ADDR_W | Top entry, 0 when empty |
| reg_sel_i | input | 2 | Register select: 0 pointer, 1 entry low, 2 entry high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current select |
| err_rst_en_i | input | 1 | Stack errors request a reset when high |
| reset_req_o | output | 1 | One-cycle reset request after a stack error |

## Verification
The assertions assume that `err_rst_en_i` is static around an error event. They also assume that the register strobe is only meaningful on cycles without a stack operation, and that holds because the block drops it otherwise. The stimulus keeps `err_rst_en_i` constant across each operation. It reads entry bytes only at indices that were earlier filled by a push, so no reset-free storage is ever observed before it is written. Every rule is exercised, including a push and a pop together, a write during a push, masked pointer writes and attempts to set the flags.

// File: rtl/rstk_pkg.sv
// Package: shared encodings of the return-address stack.
// Assumes an 8-bit register window and a 6-bit pointer field.
package rstk_pkg;
    typedef enum logic [1:0] {
        SEL_PTR    = 2'd0,
        SEL_TOS_LO = 2'd1,
        SEL_TOS_HI = 2'd2,
        SEL_NONE   = 2'd3
    } rstk_sel_e;

    localparam int          OVF_BIT    = 7;
    localparam int          UNF_BIT    = 6;
    localparam int          EMPTY_BIT  = 5;
    localparam logic [7:0]  EMPTY_CODE = 8'h20;
    localparam int          MAX_DEPTH  = 32;
endpackage

// File: rtl/rstk_ptr_ctrl.sv
// Pointer and flag controller. It holds the top index, the empty marker and
// the sticky overflow/underflow flags, and it works out the slot a push writes.
// Assumes the requests are already exclusive (pop > push > pointer write),
// and that DEPTH is a power of two between 2 and 32.
module rstk_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             do_ptr_wr,
    input  logic [2:0]       wr_flags,   // {ovf, unf, empty} bits of the write
    input  logic [PTR_W-1:0] wr_index,
    output logic             empty_q,
    output logic [PTR_W-1:0] idx_q,
    output logic             ovf_q,
    output logic             unf_q,
    output logic             push_we,
    output logic [PTR_W-1:0] push_slot,
    output logic             err_evt
);
    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

    logic             n_empty;
    logic             n_ovf;
    logic             n_unf;
    logic [PTR_W-1:0] n_idx;

    // Work out the next pointer state and any error for this cycle.
    always_comb begin
        n_empty   = empty_q;
        n_idx     = idx_q;
        n_ovf     = ovf_q;
        n_unf     = unf_q;
        push_we   = 1'b0;
        push_slot = idx_q + PTR_W'(1);
        err_evt   = 1'b0;
        if (do_pop) begin
            if (empty_q) begin
                n_unf   = 1'b1;
                err_evt = 1'b1;
            end else if (idx_q == '0) begin
                n_empty = 1'b1;
                n_idx   = '0;
            end else begin
                n_idx = idx_q - PTR_W'(1);
            end
        end else if (do_push) begin
            if (empty_q) begin
                n_empty   = 1'b0;
                n_idx     = '0;
                push_slot = '0;
                push_we   = 1'b1;
            end else if (idx_q == TOP_IDX) begin
                n_ovf   = 1'b1;
                err_evt = 1'b1;
            end else begin
                n_idx   = idx_q + PTR_W'(1);
                push_we = 1'b1;
            end
        end else if (do_ptr_wr) begin
            n_ovf   = ovf_q & wr_flags[2];
            n_unf   = unf_q & wr_flags[1];
            n_empty = wr_flags[0];
            n_idx   = wr_flags[0] ? '0 : (wr_index & TOP_IDX);
        end
    end

    // Register the pointer state; reset leaves the stack empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            empty_q <= n_empty;
            idx_q   <= n_idx;
            ovf_q   <= n_ovf;
            unf_q   <= n_unf;
        end
    end
endmodule

// File: rtl/rstk_store.sv
// Entry storage: one register per entry, a single write port and an
// asynchronous read port. It has no reset, because the entries are only
// seen through the pointer once they have been written.
module rstk_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 15,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rdata
);
    logic [ADDR_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Capture write data when this entry is addressed.
        always_ff @(posedge clk) begin
            if (we && (widx == PTR_W'(i))) begin
                ent[i] <= wdata;
            end
        end
    end

    // Read the addressed entry.
    assign rdata = ent[ridx];
endmodule

// File: rtl/rstk_regif.sv
// Register window: selects the read byte and merges a software byte write
// into the top entry. Purely combinational.
// Assumes 9 <= ADDR_W <= 16, so the high part fits in one byte.
module rstk_regif
    import rstk_pkg::*;
#(
    parameter int ADDR_W = 15,
    localparam int HI_W = ADDR_W - 8
) (
    input  rstk_sel_e         sel,
    input  logic [ADDR_W-1:0] tos,
    input  logic [7:0]        ptr_byte,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] merged
);
    // Pick the byte the current select reads.
    always_comb begin
        unique case (sel)
            SEL_PTR:    rdata = ptr_byte;
            SEL_TOS_LO: rdata = tos[7:0];
            SEL_TOS_HI: rdata = 8'(tos[ADDR_W-1:8]);
            default:    rdata = 8'h00;
        endcase
    end

    // Replace the selected byte of the top entry with the write data.
    always_comb begin
        if (sel == SEL_TOS_HI) begin
            merged = {wdata[HI_W-1:0], tos[7:0]};
        end else begin
            merged = {tos[ADDR_W-1:8], wdata};
        end
    end
endmodule

// File: rtl/ret_addr_stack.sv
// Return-address stack top level. It resolves the priority of the requests
// (pop, then push, then register write), routes the writes into storage and
// registers the reset request. Assumes err_rst_en_i is a static setting.
module ret_addr_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 15,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    output logic [ADDR_W-1:0] tos_o,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              err_rst_en_i,
    output logic              reset_req_o
);
    rstk_sel_e         sel;
    logic              do_pop, do_push, sw_wr, do_ptr_wr, tos_wr;
    logic              empty_q, ovf_q, unf_q, push_we, err_evt;
    logic [PTR_W-1:0]  idx_q, push_slot, st_widx;
    logic              st_we;
    logic [ADDR_W-1:0] st_wdata, st_rdata, merged;
    logic [7:0]        ptr_byte;

    // Resolve the request priority for this cycle.
    always_comb begin
        sel       = rstk_sel_e'(reg_sel_i);
        do_pop    = pop_i;
        do_push   = push_i & ~pop_i;
        sw_wr     = reg_wr_i & ~push_i & ~pop_i;
        do_ptr_wr = sw_wr & (sel == SEL_PTR);
        tos_wr    = sw_wr & ~empty_q & ((sel == SEL_TOS_LO) | (sel == SEL_TOS_HI));
    end

    rstk_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .do_ptr_wr (do_ptr_wr),
        .wr_flags  ({reg_wdata_i[OVF_BIT], reg_wdata_i[UNF_BIT], reg_wdata_i[EMPTY_BIT]}),
        .wr_index  (reg_wdata_i[PTR_W-1:0]),
        .empty_q   (empty_q),
        .idx_q     (idx_q),
        .ovf_q     (ovf_q),
        .unf_q     (unf_q),
        .push_we   (push_we),
        .push_slot (push_slot),
        .err_evt   (err_evt)
    );

    // Route a push or a software byte write into the store.
    always_comb begin
        st_we    = push_we | tos_wr;
        st_widx  = push_we ? push_slot : idx_q;
        st_wdata = push_we ? push_addr_i : merged;
    end

    rstk_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (st_we),
        .widx  (st_widx),
        .wdata (st_wdata),
        .ridx  (idx_q),
        .rdata (st_rdata)
    );

    // Show the top entry, or zero when nothing is stacked.
    assign tos_o    = empty_q ? '0 : st_rdata;
    assign ptr_byte = {ovf_q, unf_q, empty_q, empty_q ? 5'd0 : 5'(idx_q)};

    rstk_regif #(.ADDR_W(ADDR_W)) u_regif (
        .sel      (sel),
        .tos      (tos_o),
        .ptr_byte (ptr_byte),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .merged   (merged)
    );

    // Pulse the reset request one cycle after an enabled stack error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req_o <= 1'b0;
        end else begin
            reset_req_o <= err_evt & err_rst_en_i;
        end
    end
endmodule

// File: rtl/rstk_chk.sv
// Checker for the return-address stack, attached to every instance through
// the bind below. It watches the ports and the pointer state.
module rstk_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 15,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] tos_o,
    input logic [1:0]        reg_sel_i,
    input logic              reg_wr_i,
    input logic [7:0]        reg_wdata_i,
    input logic              err_rst_en_i,
    input logic              reset_req_o,
    input logic              empty_q,
    input logic [PTR_W-1:0]  idx_q,
    input logic              ovf_q,
    input logic              unf_q
);
    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (empty_q && !ovf_q && !unf_q && !reset_req_o));

    assert_pop_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_q && idx_q == '0) |=> empty_q);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !empty_q && idx_q == TOP_IDX)
        |=> (ovf_q && !empty_q && idx_q == TOP_IDX));

    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_q) |=> (unf_q && empty_q));

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_q |-> (tos_o == '0));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(reg_wr_i && reg_sel_i == 2'd0 && !reg_wdata_i[7])) |=> ovf_q);

    assert_ovf_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_q && !push_i) |=> !ovf_q);

    assert_unf_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!unf_q && !pop_i) |=> !unf_q);

    assert_req_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(err_rst_en_i));

    assert_pop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_q && idx_q != '0)
        |=> (!empty_q && idx_q == $past(idx_q) - PTR_W'(1)));
endmodule

bind ret_addr_stack rstk_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .tos_o        (tos_o),
    .reg_sel_i    (reg_sel_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .err_rst_en_i (err_rst_en_i),
    .reset_req_o  (reset_req_o),
    .empty_q      (empty_q),
    .idx_q        (idx_q),
    .ovf_q        (ovf_q),
    .unf_q        (unf_q)
);

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/100ps
module ret_addr_stack_tb;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 15;
    localparam int EMPTY  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0, pop_i = 1'b0, reg_wr_i = 1'b0, err_rst_en_i = 1'b0;
    logic [ADDR_W-1:0] push_addr_i = '0;
    logic [1:0]        reg_sel_i = 2'd0;
    logic [7:0]        reg_wdata_i = 8'h00;
    logic [ADDR_W-1:0] tos_o;
    logic [7:0]        reg_rdata_o;
    logic              reset_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    logic [ADDR_W-1:0] m_mem [32];
    int                m_ptr = EMPTY;
    bit                m_ovf = 0, m_unf = 0, m_req = 0;

    always #2.5 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_addr_i(push_addr_i), .tos_o(tos_o), .reg_sel_i(reg_sel_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .err_rst_en_i(err_rst_en_i), .reset_req_o(reset_req_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_tos();
        return (m_ptr == EMPTY) ? 0 : int'(m_mem[m_ptr]);
    endfunction

    function automatic int exp_reg(input int s);
        case (s)
            0: return (int'(m_ovf) << 7) | (int'(m_unf) << 6) | ((m_ptr == EMPTY) ? 32 : m_ptr);
            1: return exp_tos() & 8'hFF;
            2: return (exp_tos() >> 8) & 8'hFF;
            default: return 0;
        endcase
    endfunction

    // Advance the reference model by one clock with the given inputs.
    task automatic model(input bit ps, input bit pp, input int a, input int s,
                         input bit w, input int wd, input bit en);
        bit ev = 0;
        if (pp) begin
            if (m_ptr == EMPTY) begin m_unf = 1; ev = 1; end
            else if (m_ptr == 0) m_ptr = EMPTY;
            else m_ptr--;
        end else if (ps) begin
            if (m_ptr == EMPTY) begin m_ptr = 0; m_mem[0] = ADDR_W'(a); end
            else if (m_ptr == DEPTH - 1) begin m_ovf = 1; ev = 1; end
            else begin m_ptr++; m_mem[m_ptr] = ADDR_W'(a); end
        end else if (w) begin
            if (s == 0) begin
                m_ovf = m_ovf & wd[7];
                m_unf = m_unf & wd[6];
                m_ptr = wd[5] ? EMPTY : (wd & (DEPTH - 1));
            end else if (s == 1 && m_ptr != EMPTY) begin
                m_mem[m_ptr][7:0] = 8'(wd);
            end else if (s == 2 && m_ptr != EMPTY) begin
                m_mem[m_ptr][14:8] = 7'(wd);
            end
        end
        m_req = ev && en;
    endtask

    // One clock: drive at the falling edge, then compare every output after the rising edge.
    task automatic cyc(input string tag, input bit ps, input bit pp, input int a,
                       input int s, input bit w, input int wd, input bit en);
        push_i = ps; pop_i = pp; push_addr_i = ADDR_W'(a);
        reg_sel_i = 2'(s); reg_wr_i = w; reg_wdata_i = 8'(wd); err_rst_en_i = en;
        @(posedge clk);
        #0.2;
        model(ps, pp, a, s, w, wd, en);
        push_i = 0; pop_i = 0; reg_wr_i = 0;
        check(tag, "tos_o", int'(tos_o), exp_tos());
        check(tag, "reset_req_o", int'(reset_req_o), int'(m_req));
        for (int k = 0; k < 4; k++) begin
            reg_sel_i = 2'(k);
            #0.2;
            check(tag, $sformatf("reg%0d", k), int'(reg_rdata_o), exp_reg(k));
        end
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc("R1", 0, 0, 0, 0, 0, 0, 0);
        // R5 and R9: underflow with the request enabled, then the pulse ends
        cyc("R5", 0, 1, 0, 0, 0, 0, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 1);
        // R6: a write of 1 keeps the flag; a write of 0 clears it; a 1 cannot set it
        cyc("R6", 0, 0, 0, 0, 1, 8'h60, 0);
        cyc("R6", 0, 0, 0, 0, 1, 8'h20, 0);
        cyc("R6", 0, 0, 0, 0, 1, 8'hE0, 0);
        // R2: fill the stack
        for (int i = 0; i < DEPTH; i++) cyc("R2", 1, 0, 15'h1000 + i * 15'h0111, 0, 0, 0, 0);
        // R4 and R9: overflow with the request disabled
        cyc("R4", 1, 0, 15'h7FFF, 0, 0, 0, 0);
        // R8: byte writes to the top entry
        cyc("R8", 0, 0, 0, 1, 1, 8'hA5, 0);
        cyc("R8", 0, 0, 0, 2, 1, 8'hFF, 0);
        cyc("R8", 0, 0, 0, 3, 1, 8'h12, 0);
        // R10: push and pop together; a write dropped by a push
        cyc("R10", 1, 1, 15'h0ABC, 0, 0, 0, 0);
        cyc("R10", 1, 0, 15'h0ABC, 0, 1, 8'h20, 0);
        // R3: pop down
        cyc("R3", 0, 1, 0, 0, 0, 0, 0);
        cyc("R3", 0, 1, 0, 0, 0, 0, 0);
        // R7: pointer writes, one of them masked
        cyc("R7", 0, 0, 0, 0, 1, 8'h03, 0);
        cyc("R7", 0, 0, 0, 0, 1, 8'h0F, 0);
        cyc("R7", 0, 0, 0, 0, 1, 8'h00, 0);
        // R3: pop from index 0 empties the stack
        cyc("R3", 0, 1, 0, 0, 0, 0, 0);
        // R8: an entry write while empty is ignored, seen by moving back to index 0
        cyc("R8", 0, 0, 0, 1, 1, 8'h3C, 0);
        cyc("R8", 0, 0, 0, 0, 1, 8'h00, 0);
        // R5 and R9: underflow with the request disabled
        cyc("R3", 0, 1, 0, 0, 0, 0, 0);
        cyc("R5", 0, 1, 0, 0, 0, 0, 0);
        // R4 and R9: overflow with the request enabled
        cyc("R7", 0, 0, 0, 0, 1, 8'h07, 1);
        cyc("R9", 1, 0, 15'h1234, 0, 0, 0, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 1);
        // R6: clear only the overflow flag
        cyc("R6", 0, 0, 0, 0, 1, 8'h47, 0);
        cyc("R6", 0, 0, 0, 0, 1, 8'h07, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule